// File: doc/BRIEF.md
# Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit processor core and decides when the core may take one. It handles two source families.

External sources are each formed by ANDing a small group of pins. Each source has its own selectable low-level or edge sensitivity. Peripheral sources are status flags, each with a local enable. Software clears them either by writing zero or by reading the status and then accessing an associated register.

A pending latch is held per source. A request is taken only at an instruction boundary, and only while the global mask bit is clear. Among the eligible requests, the lowest index wins. The block then runs the core-side entry handshake. It issues four context push cycles, then sets the mask bit, then gives a one-cycle take strobe with the vector index.

A return request runs the reverse pop sequence and leaves the mask bit clear. A halt state can be left only through an external request.

Top module: `irq_ctrl`

## Requirements
- R1: No take sequence starts while `mask_o` is 1. A take starts only in the run state, at a cycle with `instr_end_i` high and at least one eligible request.
- R2: External source i uses `ext_mode_i[2i+1:2i]`. The encodings are: 00 = request while the source is low; 01 = latch on a rising edge; 10 = latch on a falling edge; 11 = latch on either edge. An edge of the direction that is not selected is ignored.
- R3: An edge-captured external request stays latched until its own take, and the take clears it automatically. A low-level request is not latched and ends when the source goes high.
- R4: External source i is the AND of `ext_pin_i[i*GRP_W +: GRP_W]`. While any pin of the group is low, a rising edge on another pin of the group does not raise a request.
- R5: A peripheral flag set by `per_set_i[j]` shows on `per_pend_o[j]`. It is taken only while `per_en_i[j]` is 1 and `mask_o` is 0; otherwise it stays pending.
- R6: A pulse on `per_wr0_i[j]` clears `per_pend_o[j]`.
- R7: A pulse on `per_rd_i[j]` while the flag is set, followed by a later pulse on `per_acc_i[j]`, clears the flag. An access pulse without such a read has no effect.
- R8: Clearing a flag that is pending but disabled discards it, so enabling the source afterwards produces no take.
- R9: Entry runs in this order:
  - four cycles with `push_o` high and `ctx_sel_o` equal to 0 (PC), 1 (X), 2 (A), then 3 (CC), with `mask_o` still 0;
  - then one cycle with `take_o` high, `mask_o` already 1, and `vec_o` holding the winner.
- R10: A pulse on `iret_i` in the run state gives four cycles with `pop_o` high and `ctx_sel_o` equal to 3, 2, 1, then 0. After that, `mask_o` is 0.
- R11: A pulse on `halt_i` in the run state enters halt (`halted_o` = 1). Only an external request leaves halt, even while masked. A pending peripheral flag does not.
- R12: Vector indices are i for external source i and N_EXT+j for peripheral j. When several requests are eligible, the lowest index wins.
- R13: After reset: `take_o`, `push_o`, `pop_o`, `mask_o`, `halted_o` and `per_pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | N_EXT*GRP_W | External pin groups |
| ext_mode_i | input | 2*N_EXT | Sensitivity code per external source |
| per_set_i | input | N_PER | Peripheral event pulses |
| per_en_i | input | N_PER | Peripheral enable bits |
| per_wr0_i | input | N_PER | Write-zero clear pulses |
| per_rd_i | input | N_PER | Status read pulses |
| per_acc_i | input | N_PER | Associated register access pulses |
| per_pend_o | output | N_PER | Peripheral pending flags |
| instr_end_i | input | 1 | Instruction boundary |
| iret_i | input | 1 | Return from interrupt |
| halt_i | input | 1 | Enter halt |
| cc_set_i | input | 1 | Set mask bit |
| cc_clr_i | input | 1 | Clear mask bit |
| mask_o | output | 1 | Global mask bit |
| push_o | output | 1 | Context push cycle |
| pop_o | output | 1 | Context pop cycle |
| ctx_sel_o | output | 2 | Context item being pushed or popped |
| take_o | output | 1 | Interrupt taken strobe |
| vec_o | output | VEC_W | Vector index of the taken source |
| halted_o | output | 1 | Core in halt |

## Verification
The assertions check several things every cycle:
- the take strobe always follows the CC push with the mask already set;
- stacking runs with the mask clear;
- pushes and pops never overlap;
- halt never ends without an external request;
- a take or write-zero clear empties the latch it targets;
- the priority grant is one-hot.

Only the scenarios can show the rest:
- edge-direction filtering;
- masking by a low pin in a group;
- the loss of a disabled flag through a clear;
- the two-step read-then-access clear;
- the priority order between peripherals;
- wake-up from halt with the mask set, with the scoreboard matching each vector against the expected queue.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STACK   = 3'd1,
    ST_VEC     = 3'd2,
    ST_UNSTACK = 3'd3,
    ST_HALT    = 3'd4
  } seq_state_e;

  localparam logic [1:0] CTX_PC = 2'd0;
  localparam logic [1:0] CTX_CC = 2'd3;

  localparam logic [1:0] MODE_LOW  = 2'b00;
  localparam logic [1:0] MODE_RISE = 2'b01;
  localparam logic [1:0] MODE_FALL = 2'b10;
  localparam logic [1:0] MODE_BOTH = 2'b11;
endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src
  import irq_pkg::*;
#(
  parameter int GRP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] pins_i,
  input  logic [1:0]       mode_i,
  input  logic             clr_i,
  output logic             req_o
);
  logic       src;
  logic [2:0] sync_q;
  logic       rise, fall, hit;
  logic       set_q, edge_q;

  // any low pin forces the combined source low
  assign src  = &pins_i;
  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    unique case (mode_i)
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      MODE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 3'b111;
      set_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], src};
      set_q  <= hit;
      if (set_q)      edge_q <= 1'b1;
      else if (clr_i) edge_q <= 1'b0;
    end
  end

  assign req_o = (mode_i == MODE_LOW) ? ~sync_q[1] : edge_q;

  AST_EDGE_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_q |=> !edge_q); // R3
endmodule

// File: rtl/irq_per_src.sv
module irq_per_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic wr0_i,
  input  logic rd_i,
  input  logic acc_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q, armed_q, clr_evt;

  assign clr_evt = wr0_i | (acc_i & armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      if (set_i)        pend_q <= 1'b1;
      else if (clr_evt) pend_q <= 1'b0;
      if (clr_evt || set_i)   armed_q <= 1'b0;
      else if (rd_i && pend_q) armed_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & en_i;

  AST_WR0_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_i && !set_i |=> !pend_q); // R6
  AST_ACC_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !armed_q && !wr0_i && !set_i |=> $stable(pend_q)); // R7
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o
);
  logic [N-1:0] gnt;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found  = 1'b1;
        gnt[i] = 1'b1;
        idx_o  = VW'(i);
      end
    end
  end

  assign any_o = |req_i;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt)); // R12
  AST_GNT_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> $countones(gnt) == 1); // R12
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int VW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_end_i,
  input  logic          iret_i,
  input  logic          halt_i,
  input  logic          cc_set_i,
  input  logic          cc_clr_i,
  input  logic          req_any_i,
  input  logic [VW-1:0] req_idx_i,
  input  logic          wake_i,
  output logic          mask_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [1:0]    ctx_sel_o,
  output logic          take_o,
  output logic [VW-1:0] vec_o,
  output logic          halted_o
);
  seq_state_e    state_q, state_d;
  logic [1:0]    cnt_q;
  logic          ibit_q;
  logic [VW-1:0] vec_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt_i)                                     state_d = ST_HALT;
        else if (instr_end_i && !ibit_q && req_any_i)   state_d = ST_STACK;
        else if (iret_i)                                state_d = ST_UNSTACK;
      end
      ST_STACK:   if (cnt_q == 2'd3) state_d = ST_VEC;
      ST_VEC:     state_d = ST_RUN;
      ST_UNSTACK: if (cnt_q == 2'd3) state_d = ST_RUN;
      ST_HALT:    if (wake_i) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      ibit_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? 2'd0 : cnt_q + 2'd1;
      if (state_q == ST_RUN && state_d == ST_STACK) vec_q <= req_idx_i;
      unique case (state_q)
        ST_STACK:   if (cnt_q == 2'd3) ibit_q <= 1'b1;
        ST_UNSTACK: if (cnt_q == 2'd3) ibit_q <= 1'b0;
        ST_RUN: begin
          if (cc_set_i)      ibit_q <= 1'b1;
          else if (cc_clr_i) ibit_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign mask_o    = ibit_q;
  assign push_o    = (state_q == ST_STACK);
  assign pop_o     = (state_q == ST_UNSTACK);
  assign ctx_sel_o = push_o ? cnt_q : (pop_o ? 2'd3 - cnt_q : 2'd0);
  assign take_o    = (state_q == ST_VEC);
  assign vec_o     = vec_q;
  assign halted_o  = (state_q == ST_HALT);

  AST_STACK_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !mask_o); // R1
  AST_TAKE_AFTER_CC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(push_o) && $past(ctx_sel_o) == CTX_CC); // R9
  AST_TAKE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> mask_o); // R9
  AST_RET_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o && ctx_sel_o == CTX_PC |=> !mask_o); // R10
  AST_NO_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && pop_o)); // R9
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !wake_i |=> halted_o); // R11
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_EXT = 2,
  parameter int N_PER = 3,
  parameter int GRP_W = 2,
  localparam int N_SRC = N_EXT + N_PER,
  localparam int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_EXT*GRP_W-1:0] ext_pin_i,
  input  logic [2*N_EXT-1:0]     ext_mode_i,
  input  logic [N_PER-1:0]       per_set_i,
  input  logic [N_PER-1:0]       per_en_i,
  input  logic [N_PER-1:0]       per_wr0_i,
  input  logic [N_PER-1:0]       per_rd_i,
  input  logic [N_PER-1:0]       per_acc_i,
  output logic [N_PER-1:0]       per_pend_o,
  input  logic                   instr_end_i,
  input  logic                   iret_i,
  input  logic                   halt_i,
  input  logic                   cc_set_i,
  input  logic                   cc_clr_i,
  output logic                   mask_o,
  output logic                   push_o,
  output logic                   pop_o,
  output logic [1:0]             ctx_sel_o,
  output logic                   take_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   halted_o
);
  logic [N_SRC-1:0] req_all;
  logic             req_any;
  logic [VEC_W-1:0] req_idx;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    logic clr;
    assign clr = take_o && (vec_o == VEC_W'(i));
    irq_ext_src #(.GRP_W(GRP_W)) u_ext (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pins_i (ext_pin_i[i*GRP_W +: GRP_W]),
      .mode_i (ext_mode_i[2*i +: 2]),
      .clr_i  (clr),
      .req_o  (req_all[i])
    );
  end

  for (genvar j = 0; j < N_PER; j++) begin : g_per
    irq_per_src u_per (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (per_set_i[j]),
      .en_i   (per_en_i[j]),
      .wr0_i  (per_wr0_i[j]),
      .rd_i   (per_rd_i[j]),
      .acc_i  (per_acc_i[j]),
      .pend_o (per_pend_o[j]),
      .req_o  (req_all[N_EXT+j])
    );
  end

  irq_prio #(.N(N_SRC), .VW(VEC_W)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_all),
    .any_o  (req_any),
    .idx_o  (req_idx)
  );

  irq_seq #(.VW(VEC_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .instr_end_i (instr_end_i),
    .iret_i      (iret_i),
    .halt_i      (halt_i),
    .cc_set_i    (cc_set_i),
    .cc_clr_i    (cc_clr_i),
    .req_any_i   (req_any),
    .req_idx_i   (req_idx),
    .wake_i      (|req_all[N_EXT-1:0]),
    .mask_o      (mask_o),
    .push_o      (push_o),
    .pop_o       (pop_o),
    .ctx_sel_o   (ctx_sel_o),
    .take_o      (take_o),
    .vec_o       (vec_o),
    .halted_o    (halted_o)
  );
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXT = 2;
  localparam int N_PER = 3;
  localparam int GRP_W = 2;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N_EXT*GRP_W-1:0] pins;
  logic [2*N_EXT-1:0] mode;
  logic [N_PER-1:0] p_set, p_en, p_wr0, p_rd, p_acc, p_pend;
  logic instr_end, iret, halt, cc_set, cc_clr;
  logic mask, push, pop, take, halted;
  logic [1:0] ctx;
  logic [VW-1:0] vec;

  irq_ctrl #(.N_EXT(N_EXT), .N_PER(N_PER), .GRP_W(GRP_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(pins), .ext_mode_i(mode),
    .per_set_i(p_set), .per_en_i(p_en), .per_wr0_i(p_wr0), .per_rd_i(p_rd),
    .per_acc_i(p_acc), .per_pend_o(p_pend), .instr_end_i(instr_end),
    .iret_i(iret), .halt_i(halt), .cc_set_i(cc_set), .cc_clr_i(cc_clr),
    .mask_o(mask), .push_o(push), .pop_o(pop), .ctx_sel_o(ctx),
    .take_o(take), .vec_o(vec), .halted_o(halted)
  );

  int checks = 0;
  int errors = 0;
  int take_cnt = 0;
  int exp_q[$];
  logic [1:0] push_idx = 2'd0;
  logic [1:0] pop_idx = 2'd0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for takes, order checks for push/pop
  always @(negedge clk) begin
    if (rst_n) begin
      if (take) begin
        take_cnt++;
        chk(mask == 1'b1, "R9 mask set at take", int'(mask), 1);
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected take", int'(vec), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(vec) == e, "R12 vector", int'(vec), e);
        end
      end
      if (push) begin
        chk(ctx == push_idx, "R9 push order", int'(ctx), int'(push_idx));
        chk(mask == 1'b0, "R9 mask clear while stacking", int'(mask), 0);
        push_idx <= push_idx + 2'd1;
      end
      if (pop) begin
        chk(ctx == 2'd3 - pop_idx, "R10 pop order", int'(ctx), int'(2'd3 - pop_idx));
        pop_idx <= pop_idx + 2'd1;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic s_set(input int j); @(negedge clk); p_set[j] = 1'b1; @(negedge clk); p_set[j] = 1'b0; endtask
  task automatic s_wr0(input int j); @(negedge clk); p_wr0[j] = 1'b1; @(negedge clk); p_wr0[j] = 1'b0; endtask
  task automatic s_rd(input int j);  @(negedge clk); p_rd[j]  = 1'b1; @(negedge clk); p_rd[j]  = 1'b0; endtask
  task automatic s_acc(input int j); @(negedge clk); p_acc[j] = 1'b1; @(negedge clk); p_acc[j] = 1'b0; endtask
  task automatic s_iret;   @(negedge clk); iret = 1'b1;   @(negedge clk); iret = 1'b0;   endtask
  task automatic s_halt;   @(negedge clk); halt = 1'b1;   @(negedge clk); halt = 1'b0;   endtask
  task automatic s_ccset;  @(negedge clk); cc_set = 1'b1; @(negedge clk); cc_set = 1'b0; endtask
  task automatic s_ccclr;  @(negedge clk); cc_clr = 1'b1; @(negedge clk); cc_clr = 1'b0; endtask

  task automatic expect_take(input int v);
    exp_q.push_back(v);
  endtask

  task automatic wait_take(input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < 60) begin
      @(negedge clk);
      k++;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    cyc(1);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int tc;
    pins = '1; mode = 4'b0101;
    p_set = '0; p_en = '0; p_wr0 = '0; p_rd = '0; p_acc = '0;
    instr_end = 1'b1; iret = 1'b0; halt = 1'b0; cc_set = 1'b0; cc_clr = 1'b0;
    cyc(3); rst_n = 1'b1; cyc(6);

    // R13 reset state
    chk(take == 0 && push == 0 && pop == 0, "R13 strobes idle", int'({take, push, pop}), 0);
    chk(mask == 0, "R13 mask", int'(mask), 0);
    chk(halted == 0, "R13 halted", int'(halted), 0);
    chk(p_pend == 0, "R13 pending", int'(p_pend), 0);

    // R2/R3: rising-edge ext0; falling edge ignored
    pins[0] = 1'b0; cyc(8);
    chk(take_cnt == 0, "R2 falling edge ignored in rising mode", take_cnt, 0);
    expect_take(0); pins[0] = 1'b1;
    wait_take("R3 rising edge taken");
    chk(mask == 1, "R9 mask after entry", int'(mask), 1);

    // R5/R1: enabled peripheral while masked stays pending
    p_en[0] = 1'b1; s_set(0); cyc(10);
    chk(p_pend[0] == 1, "R5 flag pending", int'(p_pend[0]), 1);
    chk(take_cnt == 1, "R1 no take while masked", take_cnt, 1);
    expect_take(2); s_iret();
    wait_take("R5 peripheral taken after return");
    s_wr0(0); cyc(1);
    chk(p_pend[0] == 0, "R6 write-zero clear", int'(p_pend[0]), 0);
    p_en[0] = 1'b0; s_iret(); cyc(20);
    chk(mask == 0, "R10 mask clear after return", int'(mask), 0);
    chk(take_cnt == 2, "R3 edge latch self-cleared", take_cnt, 2);

    // R4: low pin in group masks rising edge of another pin
    pins[2] = 1'b0; cyc(5); pins[3] = 1'b0; cyc(6); pins[3] = 1'b1; cyc(10);
    chk(take_cnt == 2, "R4 low pin masks rising edge", take_cnt, 2);
    expect_take(1); pins[2] = 1'b1;
    wait_take("R4 group rises when all pins high");
    s_iret(); cyc(20);

    // R2/R3: low-level mode
    mode[1:0] = 2'b00; cyc(6);
    chk(take_cnt == 3, "R2 high level gives no request", take_cnt, 3);
    expect_take(0); pins[1:0] = 2'b00;
    wait_take("R2 low level taken");
    pins[1:0] = 2'b11; cyc(6); s_iret(); cyc(20);
    chk(take_cnt == 4, "R3 level request not latched", take_cnt, 4);
    mode[1:0] = 2'b01; cyc(4);

    // R8: pending disabled request dropped by clear
    s_set(1); cyc(4);
    chk(p_pend[1] == 1, "R8 disabled flag pending", int'(p_pend[1]), 1);
    s_wr0(1); cyc(1);
    chk(p_pend[1] == 0, "R8 clear drops pending", int'(p_pend[1]), 0);
    p_en[1] = 1'b1; cyc(15);
    chk(take_cnt == 4, "R8 no take after enable", take_cnt, 4);
    p_en[1] = 1'b0;

    // R7: read-then-access clear
    s_set(2); s_acc(2); cyc(1);
    chk(p_pend[2] == 1, "R7 access alone has no effect", int'(p_pend[2]), 1);
    s_rd(2); s_acc(2); cyc(1);
    chk(p_pend[2] == 0, "R7 read then access clears", int'(p_pend[2]), 0);

    // R12: priority between peripherals
    s_ccset(); p_en[1] = 1'b1; p_en[2] = 1'b1; s_set(2); s_set(1); cyc(10);
    chk(take_cnt == 4, "R1 masked by software", take_cnt, 4);
    expect_take(3); s_ccclr();
    wait_take("R12 lowest index first");
    s_wr0(1); expect_take(4); s_iret();
    wait_take("R12 next source after return");
    s_wr0(2); s_iret(); cyc(15);
    chk(mask == 0, "R10 mask clear", int'(mask), 0);
    p_en = '0;

    // R11: halt, peripheral does not wake, external falling edge does
    mode[3:2] = 2'b10; cyc(4);
    s_ccset(); p_en[0] = 1'b1; s_set(0); s_halt(); cyc(3);
    chk(halted == 1, "R11 halted", int'(halted), 1);
    cyc(15);
    chk(halted == 1, "R11 peripheral does not wake", int'(halted), 1);
    tc = take_cnt;
    pins[2] = 1'b0; cyc(10);
    chk(halted == 0, "R11 external wakes", int'(halted), 0);
    chk(take_cnt == tc, "R1 no take after wake while masked", take_cnt, tc);
    s_wr0(0); p_en[0] = 1'b0; expect_take(1); s_ccclr();
    wait_take("R11 woken request taken");
    pins[2] = 1'b1; cyc(8);
    chk(take_cnt == tc + 1, "R2 rising ignored in falling mode", take_cnt, tc + 1);
    s_iret(); cyc(20);
    chk(exp_q.size() == 0 && take_cnt == tc + 1, "R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule